// File: doc/BRIEF.md
# Two-Dimensional Pattern Fill Sequencer

This block writes a rectangular pattern into a single-port memory, one word per clock cycle. After a start pulse it walks a row index and a column index, the column index being the inner one, and emits a write for every (row, column) pair. The writes go to consecutive addresses beginning at a base address supplied with the start pulse. The word written at each step is a pure function of the two indices.

The row count, column count and base address are inputs. They are captured on the cycle the start pulse is accepted. A done flag reports that the last element has been written. The sequencer can be started again once a fill has finished, for example when a table has to be re-initialised with different dimensions.

Top module: `fill2d_init`

## Requirements
- R1: While reset is held and on the first cycle after it, `mem_we` and `done` are both 0.
- R2: A start pulse accepted while no fill is running, with non-zero counts, makes the first write appear in the cycle after the start edge, with `mem_addr` equal to `base_addr` and `done` cleared.
- R3: A fill with R rows and C columns drives `mem_we` high on exactly R*C consecutive cycles, with one write per cycle.
- R4: `mem_addr` rises by one after every write, modulo 2^ADDR_W, starting from the captured base address.
- R5: Write k carries row i = k / C and column j = k mod C. The column advances first and wraps to 0 as the row advances. The data is ((i*C + j) XOR KEY), truncated to DATA_W bits.
- R6: `done` rises together with the fall of `mem_we` after the last write. It stays 1 with `mem_we` at 0 until the next accepted start.
- R7: A start pulse that arrives while a fill is running is ignored, and the running fill continues unchanged.
- R8: After a fill completes, a new start runs a complete new fill with the newly supplied base and counts.
- R9: A start with a zero row count or a zero column count produces no write and sets `done` in the cycle after the start edge.
- R10: Changing `base_addr`, `num_rows` or `num_cols` during a fill has no effect on the writes of that fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin a fill |
| base_addr | input | ADDR_W | First address of the region, captured at start |
| num_rows | input | ROW_W | Number of rows (outer index), captured at start |
| num_cols | input | COL_W | Number of columns (inner index), captured at start |
| mem_we | output | 1 | Memory write enable, registered |
| mem_addr | output | ADDR_W | Memory write address, registered |
| mem_wdata | output | DATA_W | Memory write data, registered |
| done | output | 1 | High once the last element has been written |

## Verification
The fill is run over several shapes: a square block, a single element, a single row, a single column, and a full 15x15 region. The single row has only inner-index steps and the single column has only wraps, so each one isolates one half of the index update. Two base addresses close to the top of the address space show whether the address wraps modulo the address width, independently of the indices. A start pulse with altered inputs is injected mid-fill, and a new fill is started the moment done appears. These show whether captured parameters are protected, and whether restart clears the previous run's state. Zero row and zero column starts check the degenerate completion path.

// File: rtl/fill2d_pkg.sv
package fill2d_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } fill_state_e;
endpackage

// File: rtl/fill2d_idx.sv
// Nested row/column counters; the column is the inner index.
module fill2d_idx #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [ROW_W-1:0] lim_row,
  input  logic [COL_W-1:0] lim_col,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic [ROW_W-1:0] nxt_row,
  output logic [COL_W-1:0] nxt_col,
  output logic             last_elem
);
  logic col_wrap;

  always_comb begin
    col_wrap  = (col_q == lim_col);
    last_elem = col_wrap && (row_q == lim_row);
    nxt_row   = row_q;
    nxt_col   = col_q;
    if (load) begin
      nxt_row = '0;
      nxt_col = '0;
    end else if (step) begin
      if (col_wrap) begin
        nxt_col = '0;
        nxt_row = row_q + 1'b1;
      end else begin
        nxt_col = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= nxt_row;
      col_q <= nxt_col;
    end
  end

  // R5: the column never passes its limit while stepping
  p_col_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    step |-> (col_q <= lim_col));
  // R5: a column wrap advances the row by one
  p_row_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && col_wrap) |=> (col_q == '0) && (row_q == $past(row_q) + 1'b1));
endmodule

// File: rtl/fill2d_addr.sv
// Linear write address generator.
module fill2d_addr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= base;
    else if (step) addr_q <= addr_q + 1'b1;
  end

  // R4: each step moves the address by exactly one
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/fill2d_data.sv
// Pattern word as a pure function of the indices.
module fill2d_data #(
  parameter int                ROW_W  = 4,
  parameter int                COL_W  = 4,
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY    = 16'h5A3C
) (
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [COL_W-1:0]  ncols,
  output logic [DATA_W-1:0] word
);
  localparam int LIN_W = ROW_W + COL_W;
  logic [LIN_W-1:0] lin;

  always_comb begin
    lin  = LIN_W'(row) * LIN_W'(ncols) + LIN_W'(col);
    word = DATA_W'(lin) ^ KEY;
  end
endmodule

// File: rtl/fill2d_init.sv
module fill2d_init
  import fill2d_pkg::*;
#(
  parameter int                ROW_W  = 4,
  parameter int                COL_W  = 4,
  parameter int                ADDR_W = 10,
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY    = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ROW_W-1:0]  num_rows,
  input  logic [COL_W-1:0]  num_cols,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done
);
  fill_state_e       state_q;
  logic [ROW_W-1:0]  lim_row_q;
  logic [COL_W-1:0]  lim_col_q;
  logic [COL_W-1:0]  ncols_q;
  logic [ADDR_W-1:0] base_q;
  logic              accept, zero_req, step;
  logic              last_elem;
  logic [ROW_W-1:0]  row_q, nxt_row;
  logic [COL_W-1:0]  col_q, nxt_col;
  logic [DATA_W-1:0] word;

  always_comb begin
    accept   = start && (state_q != ST_FILL);
    zero_req = (num_rows == '0) || (num_cols == '0);
    step     = (state_q == ST_FILL) && !last_elem;
  end

  fill2d_idx #(.ROW_W(ROW_W), .COL_W(COL_W)) u_idx (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .lim_row(lim_row_q), .lim_col(lim_col_q),
    .row_q(row_q), .col_q(col_q),
    .nxt_row(nxt_row), .nxt_col(nxt_col), .last_elem(last_elem)
  );

  fill2d_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .base(base_addr), .addr_q(mem_addr)
  );

  fill2d_data #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .KEY(KEY)) u_data (
    .row(nxt_row), .col(nxt_col), .ncols(ncols_q), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mem_we    <= 1'b0;
      done      <= 1'b0;
      mem_wdata <= '0;
      lim_row_q <= '0;
      lim_col_q <= '0;
      ncols_q   <= '0;
      base_q    <= '0;
    end else if (accept) begin
      lim_row_q <= num_rows - 1'b1;
      lim_col_q <= num_cols - 1'b1;
      ncols_q   <= num_cols;
      base_q    <= base_addr;
      mem_wdata <= word;
      if (zero_req) begin
        state_q <= ST_DONE;
        mem_we  <= 1'b0;
        done    <= 1'b1;
      end else begin
        state_q <= ST_FILL;
        mem_we  <= 1'b1;
        done    <= 1'b0;
      end
    end else if (state_q == ST_FILL) begin
      if (last_elem) begin
        state_q <= ST_DONE;
        mem_we  <= 1'b0;
        done    <= 1'b1;
      end else begin
        mem_wdata <= word;
      end
    end
  end

  // R6: no write is issued while done is reported
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);
  // R6: the end of a write burst is always a completion
  p_end_sets_done_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we) |-> done);
  // R2: a burst opens at the captured base address
  p_first_at_base_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> (mem_addr == base_q));
  // R5: element (0,0) carries the bare key
  p_first_word_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> (mem_wdata == KEY));
  // R7: a start during a running fill does not stop it
  p_busy_ignores_start_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && start && !last_elem) |=> mem_we);
endmodule

// File: tb/fill2d_init_test.sv
module fill2d_init_test;
  localparam int          ROW_W  = 4;
  localparam int          COL_W  = 4;
  localparam int          ADDR_W = 10;
  localparam int          DATA_W = 16;
  localparam logic [15:0] KEY    = 16'h5A3C;
  localparam int          NV     = 6;
  localparam int V_BASE [NV] = '{0, 5, 100, 200, 1000, 1023};
  localparam int V_ROWS [NV] = '{3, 1, 1,   6,   15,   2};
  localparam int V_COLS [NV] = '{4, 1, 7,   1,   15,   3};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [ROW_W-1:0]  num_rows = '0;
  logic [COL_W-1:0]  num_cols = '0;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              done;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fill2d_init #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
                .DATA_W(DATA_W), .KEY(KEY)) uut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .num_rows(num_rows), .num_cols(num_cols), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int i, input int j, input int c);
    return 16'(i * c + j) ^ KEY;
  endfunction

  // Runs one fill; poke injects a start with altered inputs during write 2.
  task automatic run_fill(input int b, input int r, input int c, input bit poke);
    int n;
    n = r * c;
    @(negedge clk);
    base_addr = ADDR_W'(b);
    num_rows  = ROW_W'(r);
    num_cols  = COL_W'(c);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(!mem_we, "R9 no write on zero count", int'(mem_we), 0);
      chk(done, "R9 done after zero count", int'(done), 1);
      return;
    end
    for (int k = 0; k < n; k++) begin
      int i = k / c;
      int j = k % c;
      logic [ADDR_W-1:0] ea = ADDR_W'(b + k);
      chk(mem_we, "R3 write enable in fill", int'(mem_we), 1);
      chk(!done, "R2 done cleared during fill", int'(done), 0);
      chk(mem_addr == ea, "R4 address", int'(mem_addr), int'(ea));
      chk(mem_wdata == exp_word(i, j, c), "R5 data", int'(mem_wdata),
          int'(exp_word(i, j, c)));
      if (poke && k == 2) begin
        start     = 1'b1;
        base_addr = ADDR_W'(b + 77);
        num_rows  = ROW_W'(1);
        num_cols  = COL_W'(2);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(!mem_we, "R3 write enable drops after last", int'(mem_we), 0);
    chk(done, "R6 done after last write", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_we && !done, "R1 outputs in reset", int'({mem_we, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_we && !done, "R1 outputs after reset", int'({mem_we, done}), 0);

    for (int v = 0; v < NV; v++) run_fill(V_BASE[v], V_ROWS[v], V_COLS[v], 1'b0);

    // R6: done holds while idle
    repeat (4) @(negedge clk);
    chk(done && !mem_we, "R6 done held while idle", int'({done, mem_we}), 2);

    // R7, R10: start and input changes mid-fill are ignored
    run_fill(300, 3, 5, 1'b1);
    // R8: immediate restart with new shape
    run_fill(40, 4, 2, 1'b0);
    // R9: zero rows, zero columns
    run_fill(10, 0, 5, 1'b0);
    run_fill(10, 5, 0, 1'b0);
    // R8: restart after a zero-count run
    run_fill(512, 2, 2, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule